// File: doc/BRIEF.md
# Integer Add Unit with Carry and Overflow Flags

This block executes a family of 32-bit two's-complement add operations for an integer pipeline stage and keeps a three-bit flag register: a carry flag, an overflow flag and a sticky summary-overflow flag. Register-register adds can take the stored carry as carry-in, add minus one or zero to it, and record signed overflow when the operation's overflow-enable bit is set. Immediate adds take a 16-bit immediate from the low half of operand B. The immediate is sign-extended, or placed in the upper half of the word for the shifted form. An A-operand selector of zero then means a literal zero.

The result is registered: it appears, with a valid pulse, on the clock edge that follows an accepted operation. When the operation asks for a record, a strobe for the condition register rises in the same cycle as the valid pulse. A separate flag-write port loads all three flags directly. This port is the only way to clear the sticky bit. Instruction decode and register file access belong to the surrounding pipeline.

Top module: `addu_top`

## Requirements
- R1: After a synchronous active-low reset, result is 0, res_valid and cr_rec_strobe are 0, and flag_ca, flag_ov, flag_so are 0.
- R2: With op_code 0 (plain add) or 1 (add carrying), the cycle after op_valid shows res_valid=1 and result = opnd_a + opnd_b modulo 2^32.
- R3: Using the carry flag held before the operation: op_code 2 gives opnd_a + opnd_b + carry, op_code 3 gives opnd_a + carry - 1, and op_code 4 gives opnd_a + carry. All results are modulo 2^32.
- R4: The immediate imm = opnd_b[15:0]. op_code 5 gives A + sign-extended imm, op_code 6 gives A + (imm << 16), and op_code 7 (immediate carrying) gives opnd_a + sign-extended imm. For op_codes 5 and 6, A is 0 when a_is_zero=1 and opnd_a otherwise; op_code 7 ignores a_is_zero.
- R5: op_codes 1, 2, 3, 4 and 7 load flag_ca with the carry out of bit 31 of the full sum, including the carry-in. op_codes 0, 5 and 6 leave flag_ca unchanged.
- R6: op_codes 0 to 4 with ovf_en=1 load flag_ov with signed overflow: both addends have the same sign and the sum's sign differs. For op_code 3 the second addend is all ones, and for op_code 4 it is zero. When ovf_en=0, or for op_codes 5 to 7, flag_ov is unchanged.
- R7: flag_so becomes 1 whenever an operation sets flag_ov, and then stays 1 through any number of operations, including enabled operations without overflow, until a flag write.
- R8: flag_wr=1 loads flag_so=flag_wr_data[2], flag_ov=flag_wr_data[1] and flag_ca=flag_wr_data[0] on the next edge. It takes priority over any arithmetic flag update in the same cycle, but the result of that operation is still produced.
- R9: cr_rec_strobe is 1 exactly in the cycles where res_valid is 1 for an operation issued with rec_en=1. When op_valid=0, res_valid is 0 and result keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | Operation issued this cycle |
| op_code | input | 3 | Add variant, encodings as in R2 to R4 |
| opnd_a | input | 32 | Operand A |
| opnd_b | input | 32 | Operand B; low 16 bits are the immediate |
| ovf_en | input | 1 | Overflow-enable bit of the operation |
| a_is_zero | input | 1 | A selector is zero (immediate forms 5 and 6) |
| rec_en | input | 1 | Request a condition-register record |
| flag_wr | input | 1 | Direct flag-register write |
| flag_wr_data | input | 3 | Write data {so, ov, ca} |
| result | output | 32 | Registered sum |
| res_valid | output | 1 | Result valid pulse |
| cr_rec_strobe | output | 1 | Condition-register record strobe |
| flag_ca | output | 1 | Carry flag |
| flag_ov | output | 1 | Overflow flag |
| flag_so | output | 1 | Sticky summary-overflow flag |

## Verification
Random operands in a seeded stream exercise all eight op codes. The ovf_en and a_is_zero bits are drawn at random, and flag writes arrive now and then, so carry chaining between extended adds is exercised with both stored carry values. Directed cases cover several boundaries. An all-ones plus one add separates carry from overflow. A largest-positive plus one add sets overflow without carry. A later enabled add without overflow shows that the sticky bit holds while overflow clears. Minus-one and zero extended adds at zero and all-ones show the edges of their carry-out. A shifted immediate with the zero selector checks the placement of the upper half, and a flag write in the same cycle as a carrying add shows which update wins.

// File: rtl/addu_pkg.sv
// Package for the add unit: operation encodings and class helpers.
// Assumes a 3-bit operation code issued by the pipeline decode.
package addu_pkg;

    typedef enum logic [2:0] {
        ADDU_ADD   = 3'd0,
        ADDU_ADDC  = 3'd1,
        ADDU_ADDE  = 3'd2,
        ADDU_ADDME = 3'd3,
        ADDU_ADDZE = 3'd4,
        ADDU_ADDI  = 3'd5,
        ADDU_ADDIS = 3'd6,
        ADDU_ADDIC = 3'd7
    } addu_op_e;

    // True for variants whose carry-out is stored in the carry flag.
    function automatic logic op_writes_carry(addu_op_e op);
        return (op == ADDU_ADDC) || (op == ADDU_ADDE) || (op == ADDU_ADDME) ||
               (op == ADDU_ADDZE) || (op == ADDU_ADDIC);
    endfunction

    // True for register-register variants that honour the overflow enable.
    function automatic logic op_is_regreg(addu_op_e op);
        return (op == ADDU_ADD) || (op == ADDU_ADDC) || (op == ADDU_ADDE) ||
               (op == ADDU_ADDME) || (op == ADDU_ADDZE);
    endfunction

endpackage

// File: rtl/addu_operand_sel.sv
// Operand selection for the add unit: picks the two addends and the
// carry-in for each variant. Assumes IMM_W is half of W (shifted form).
module addu_operand_sel
    import addu_pkg::*;
#(
    parameter int unsigned W     = 32,
    parameter int unsigned IMM_W = W / 2
) (
    input  addu_op_e       op,
    input  logic [W-1:0]   a_in,
    input  logic [W-1:0]   b_in,
    input  logic           a_zero,
    input  logic           ca_in,
    output logic [W-1:0]   x_out,
    output logic [W-1:0]   y_out,
    output logic           cin_out
);
    localparam int unsigned PAD_W = W - IMM_W;

    logic [IMM_W-1:0] imm;
    logic [W-1:0]     imm_sext;
    logic [W-1:0]     imm_high;
    logic [W-1:0]     a_or_zero;

    assign imm       = b_in[IMM_W-1:0];
    assign imm_sext  = {{PAD_W{imm[IMM_W-1]}}, imm};
    assign imm_high  = {imm, {PAD_W{1'b0}}};
    assign a_or_zero = a_zero ? '0 : a_in;

    // Choose addends and carry-in per variant.
    always_comb begin
        x_out   = a_in;
        y_out   = b_in;
        cin_out = 1'b0;
        case (op)
            ADDU_ADD, ADDU_ADDC: begin
                y_out = b_in;
            end
            ADDU_ADDE: begin
                cin_out = ca_in;
            end
            ADDU_ADDME: begin
                y_out   = '1;
                cin_out = ca_in;
            end
            ADDU_ADDZE: begin
                y_out   = '0;
                cin_out = ca_in;
            end
            ADDU_ADDI: begin
                x_out = a_or_zero;
                y_out = imm_sext;
            end
            ADDU_ADDIS: begin
                x_out = a_or_zero;
                y_out = imm_high;
            end
            ADDU_ADDIC: begin
                y_out = imm_sext;
            end
            default: begin
                y_out = b_in;
            end
        endcase
    end
endmodule

// File: rtl/addu_sum.sv
// Adder core: W-bit sum with carry-in, carry-out and signed overflow.
// Assumes two's-complement operands; purely combinational.
module addu_sum #(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout,
    output logic         ovf
);
    logic [W:0] wide;

    // Full-width sum including carry-in.
    always_comb begin
        wide = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, cin};
    end

    assign sum  = wide[W-1:0];
    assign cout = wide[W];
    assign ovf  = (x[W-1] == y[W-1]) && (wide[W-1] != x[W-1]);
endmodule

// File: rtl/addu_flag_reg.sv
// Flag register: carry, overflow and sticky summary overflow.
// Assumes update strobes come from decode; direct write has priority.
module addu_flag_reg (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr,
    input  logic [2:0] wr_data,
    input  logic       ca_upd,
    input  logic       ca_new,
    input  logic       ov_upd,
    input  logic       ov_new,
    output logic       ca,
    output logic       ov,
    output logic       so
);
    // Flag state update with write priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ca <= 1'b0;
            ov <= 1'b0;
            so <= 1'b0;
        end else if (wr) begin
            so <= wr_data[2];
            ov <= wr_data[1];
            ca <= wr_data[0];
        end else begin
            if (ca_upd) ca <= ca_new;
            if (ov_upd) begin
                ov <= ov_new;
                if (ov_new) so <= 1'b1;
            end
        end
    end

    p_so_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (so && !wr) |=> so);
    p_ov_sets_so_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ov_upd && ov_new && !wr) |=> so);
    p_ca_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!ca_upd && !wr) |=> $stable(ca));
    p_ov_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!ov_upd && !wr) |=> $stable(ov));
    p_wr_prio_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> ({so, ov, ca} == $past(wr_data)));
endmodule

// File: rtl/addu_top.sv
// Integer add unit top: selects operands, adds, registers the result
// and record strobe, and drives flag updates. Assumes one op per cycle.
module addu_top
    import addu_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         op_valid,
    input  logic [2:0]   op_code,
    input  logic [W-1:0] opnd_a,
    input  logic [W-1:0] opnd_b,
    input  logic         ovf_en,
    input  logic         a_is_zero,
    input  logic         rec_en,
    input  logic         flag_wr,
    input  logic [2:0]   flag_wr_data,
    output logic [W-1:0] result,
    output logic         res_valid,
    output logic         cr_rec_strobe,
    output logic         flag_ca,
    output logic         flag_ov,
    output logic         flag_so
);
    addu_op_e     op;
    logic [W-1:0] x, y, sum;
    logic         cin, cout, ovf;
    logic         ca_upd, ov_upd;

    assign op = addu_op_e'(op_code);

    addu_operand_sel #(.W(W)) u_sel (
        .op(op), .a_in(opnd_a), .b_in(opnd_b), .a_zero(a_is_zero),
        .ca_in(flag_ca), .x_out(x), .y_out(y), .cin_out(cin)
    );

    addu_sum #(.W(W)) u_sum (
        .x(x), .y(y), .cin(cin), .sum(sum), .cout(cout), .ovf(ovf)
    );

    // Decode which flags this operation may update.
    always_comb begin
        ca_upd = op_valid && op_writes_carry(op);
        ov_upd = op_valid && ovf_en && op_is_regreg(op);
    end

    addu_flag_reg u_flags (
        .clk(clk), .rst_n(rst_n), .wr(flag_wr), .wr_data(flag_wr_data),
        .ca_upd(ca_upd), .ca_new(cout), .ov_upd(ov_upd), .ov_new(ovf),
        .ca(flag_ca), .ov(flag_ov), .so(flag_so)
    );

    // Result register with valid and record strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result        <= '0;
            res_valid     <= 1'b0;
            cr_rec_strobe <= 1'b0;
        end else begin
            res_valid     <= op_valid;
            cr_rec_strobe <= op_valid && rec_en;
            if (op_valid) result <= sum;
        end
    end

    p_rec_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cr_rec_strobe |-> res_valid);
    p_result_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> (!res_valid && $stable(result)));
    p_valid_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |=> res_valid);
endmodule

// File: tb/test_addu_top.sv
module test_addu_top;
    localparam int unsigned CLK_PERIOD = 10;
    localparam int unsigned WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [2:0]  op_code = '0;
    logic [31:0] opnd_a = '0, opnd_b = '0;
    logic        ovf_en = 1'b0, a_is_zero = 1'b0, rec_en = 1'b0;
    logic        flag_wr = 1'b0;
    logic [2:0]  flag_wr_data = '0;
    logic [31:0] result;
    logic        res_valid, cr_rec_strobe, flag_ca, flag_ov, flag_so;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    bit finished = 1'b0;

    // model flag state
    bit m_ca = 0, m_ov = 0, m_so = 0;
    logic [31:0] m_res = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    addu_top i_addu_top (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .ovf_en(ovf_en),
        .a_is_zero(a_is_zero), .rec_en(rec_en), .flag_wr(flag_wr),
        .flag_wr_data(flag_wr_data), .result(result), .res_valid(res_valid),
        .cr_rec_strobe(cr_rec_strobe), .flag_ca(flag_ca), .flag_ov(flag_ov),
        .flag_so(flag_so)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Reference computation from the requirements, via signed/unsigned 64-bit sums.
    function automatic logic [33:0] ref_add(input int op, input logic [31:0] a,
                                            input logic [31:0] b, input bit az, input bit ca);
        longint unsigned ua, ub, us;
        longint sa, sb, ss;
        logic [31:0] ea, eb;
        bit cin, ov;
        ea = a; eb = b; cin = 0;
        case (op)
            2: cin = ca;
            3: begin eb = 32'hFFFF_FFFF; cin = ca; end
            4: begin eb = 32'h0; cin = ca; end
            5: begin ea = az ? 32'h0 : a; eb = {{16{b[15]}}, b[15:0]}; end
            6: begin ea = az ? 32'h0 : a; eb = {b[15:0], 16'h0}; end
            7: eb = {{16{b[15]}}, b[15:0]};
            default: ;
        endcase
        ua = longint'(ea); ub = longint'(eb);
        us = ua + ub + longint'(cin);
        sa = longint'($signed(ea)); sb = longint'($signed(eb));
        ss = sa + sb + longint'(cin);
        ov = (ss > 64'sd2147483647) || (ss < -64'sd2147483648);
        return {us[32], ov, us[31:0]};
    endfunction

    function automatic string res_tag(input int op);
        if (op <= 1) return "R2";
        if (op <= 4) return "R3";
        return "R4";
    endfunction

    task automatic do_op(input int op, input logic [31:0] a, input logic [31:0] b,
                         input bit oe, input bit az, input bit rec,
                         input bit wr, input logic [2:0] wd);
        logic [33:0] r;
        bit carrying, regreg, prev_so;
        @(negedge clk);
        op_valid = 1; op_code = op[2:0]; opnd_a = a; opnd_b = b;
        ovf_en = oe; a_is_zero = az; rec_en = rec; flag_wr = wr; flag_wr_data = wd;
        r = ref_add(op, a, b, az, m_ca);
        carrying = (op >= 1 && op <= 4) || op == 7;
        regreg = op <= 4;
        prev_so = m_so;
        m_res = r[31:0];
        if (wr) begin
            m_so = wd[2]; m_ov = wd[1]; m_ca = wd[0];
        end else begin
            if (carrying) m_ca = r[33];
            if (regreg && oe) begin
                m_ov = r[32];
                if (r[32]) m_so = 1;
            end
        end
        @(posedge clk); #1;
        op_valid = 0; flag_wr = 0;
        chk(res_tag(op), result, m_res);
        chk("R2 valid", {31'b0, res_valid}, 32'd1);
        chk("R9 strobe", {31'b0, cr_rec_strobe}, {31'b0, rec});
        chk(wr ? "R8 ca" : "R5 ca", {31'b0, flag_ca}, {31'b0, m_ca});
        chk(wr ? "R8 ov" : "R6 ov", {31'b0, flag_ov}, {31'b0, m_ov});
        chk(wr ? "R8 so" : (prev_so ? "R7 so" : "R6 so"), {31'b0, flag_so}, {31'b0, m_so});
    endtask

    task automatic idle_check();
        @(negedge clk);
        op_valid = 0; opnd_a = 32'hDEAD_BEEF;
        @(posedge clk); #1;
        chk("R9 idle valid", {31'b0, res_valid}, 32'd0);
        chk("R9 idle strobe", {31'b0, cr_rec_strobe}, 32'd0);
        chk("R9 idle hold", result, m_res);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles >= WATCHDOG && !finished) begin
            finished = 1;
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected<%0d", cycles, WATCHDOG);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(posedge clk);
        #1;
        chk("R1 result", result, 32'h0);
        chk("R1 valid", {30'b0, res_valid, cr_rec_strobe}, 32'h0);
        chk("R1 flags", {29'b0, flag_so, flag_ov, flag_ca}, 32'h0);
        @(negedge clk); rst_n = 1;

        // directed corner cases
        do_op(1, 32'hFFFF_FFFF, 32'h1, 1, 0, 1, 0, 3'b0);   // carry, no overflow
        do_op(0, 32'h7FFF_FFFF, 32'h1, 1, 0, 0, 0, 3'b0);   // overflow, carry held
        do_op(0, 32'h1, 32'h2, 1, 0, 1, 0, 3'b0);           // ov clears, so sticky
        do_op(0, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 0, 0, 0, 0, 3'b0); // oe=0: ov held
        do_op(2, 32'h10, 32'h20, 1, 0, 0, 0, 3'b0);         // adde with ca=1
        do_op(5, 32'h7FFF_FFFF, 32'h1, 1, 0, 0, 0, 3'b0);   // imm: no ov update
        idle_check();
        do_op(1, 32'h1, 32'h1, 0, 0, 0, 1, 3'b000);         // write wins, clears so
        do_op(3, 32'h0, 32'h0, 1, 0, 0, 0, 3'b0);           // addme 0, ca=0
        do_op(4, 32'hFFFF_FFFF, 32'h0, 1, 0, 0, 1, 3'b001); // write sets ca
        do_op(4, 32'hFFFF_FFFF, 32'h0, 1, 0, 0, 0, 3'b0);   // addze wraps, carry
        do_op(3, 32'h8000_0000, 32'h0, 1, 0, 1, 0, 3'b0);   // addme ca=1
        do_op(6, 32'h1234_5678, 32'h0000_ABCD, 0, 1, 0, 0, 3'b0); // shifted, zero sel
        do_op(5, 32'h0000_0010, 32'h0000_FFF0, 0, 0, 0, 0, 3'b0); // negative imm
        do_op(7, 32'h0000_0010, 32'h0000_FFF0, 0, 1, 0, 0, 3'b0); // addic ignores az
        do_op(6, 32'h0000_0001, 32'hFFFF_8000, 0, 0, 0, 0, 3'b0);
        do_op(0, 32'h8000_0000, 32'h8000_0000, 1, 0, 0, 1, 3'b010); // write vs ovf

        // seeded random mix
        for (int i = 0; i < 600; i++) begin
            int op;
            bit wr;
            op = $urandom_range(0, 7);
            wr = ($urandom_range(0, 15) == 0);
            do_op(op, $urandom(), $urandom(), $urandom_range(0, 1) == 1,
                  $urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1,
                  wr, 3'($urandom_range(0, 7)));
            if ($urandom_range(0, 9) == 0) idle_check();
        end

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule